// File: doc/BRIEF.md
# Guarded Child-Counter Increment Unit

This block carries out a privileged request to bump the child count held for a protected-memory control page. A request arrives as a one-cycle start pulse together with two page descriptors: the page being counted (the target) and the control page it should belong to (the parent). Each descriptor arrives already resolved. It gives a physical address, a protected-memory membership bit, and for the target also a valid bit, a page type, a back-pointer to its owning control page and a busy flag. The caller also supplies its privilege level and its current arithmetic flags.

The unit runs a fixed, prioritised chain of checks on the captured request. Exactly one of three things then happens. It raises an architectural fault and names the operand that caused it. It returns a soft error with the zero flag set. Or it increments a 64-bit counter in a small internal table indexed by the parent's page address. An increment that would wrap is undone rather than saturated, and it reports an invalid-counter error. Completion is signalled by a one-cycle done pulse carrying the fault kind, the result code, the updated flags and the slot's counter value.

Top module: `child_count_unit`

## Requirements
- R1: A privilege level other than 0 raises a general-protection fault (fault_o = 1) on the target operand (fault_opnd_o = 0), ahead of every other check.
- R2: With privilege 0, a target address whose low 12 bits are not all zero raises a general-protection fault on the target.
- R3: The remaining page-fault checks (fault_o = 2) are taken in this order: target outside protected memory (operand 0), then parent outside protected memory (operand 1), then the busy check of R4, then target entry invalid (operand 0).
- R4: A busy target that passes the earlier checks sets ZF and returns CONFLICT_RC with fault_o = 0, and leaves the counter unchanged. count_o shows the unchanged value.
- R5: Page type codes: 0 control page, 1 regular, 2 thread-control, 3 trimmed. Types 1 to 3 resolve the parent from the back-pointer, and type 0 resolves it to the target's own address. Any other code raises a page fault on the target.
- R6: A resolved parent address that differs from the parent descriptor's address raises a general-protection fault on the parent operand (fault_opnd_o = 1).
- R7: On success the slot's counter rises by one, count_o shows the new value, rc_o is 0 and all six flags are cleared.
- R8: When the stored counter is all ones, the increment is undone. The counter keeps its value, ZF is set, the other five flags are cleared and rc_o is BADCNT_RC.
- R9: On a fault, flags_o repeats the flags_i captured with the request, rc_o and count_o are 0, and no counter changes.
- R10: done_o is a single-cycle pulse on the second clock edge after the edge that accepts start_i. A start pulse that arrives while a request is pending is ignored.
- R11: Flag bit positions are CF 0, PF 1, AF 2, ZF 3, SF 4, OF 5. Each parent page selects its own counter through address bits [12 +: log2(SLOTS)], and all counters reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse |
| priv_i | input | 2 | Caller privilege level |
| flags_i | input | 6 | Caller arithmetic flags |
| tgt_addr_i | input | ADDR_W | Target page physical address |
| tgt_prot_i | input | 1 | Target lies in protected memory |
| tgt_valid_i | input | 1 | Target entry valid |
| tgt_type_i | input | 3 | Target page type code |
| tgt_back_i | input | ADDR_W | Target back-pointer to owning control page |
| tgt_busy_i | input | 1 | Target busy with another operation |
| par_addr_i | input | ADDR_W | Parent control page physical address |
| par_prot_i | input | 1 | Parent lies in protected memory |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 2 | 0 none, 1 general-protection, 2 page fault |
| fault_opnd_o | output | 1 | Faulting operand: 0 target, 1 parent |
| rc_o | output | RC_W | Result code |
| flags_o | output | 6 | Resulting flags |
| count_o | output | CNT_W | Counter value of the addressed slot after the request |

## Verification
The assertions assume that start_i is held for one cycle per request and that the descriptor inputs stay steady during the cycle in which they are accepted. The bench drives every request on the falling edge, releases start_i on the next falling edge and waits for done_o before it issues another. The one exception is a deliberate back-to-back pulse that shows a pending request rejects a second start. The bench runs with a 4-bit counter so that the wrap-undo path is reached after fifteen increments, and it keeps its own per-slot count to predict count_o.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_PF   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ACT_FAULT    = 2'd0,
    ACT_CONFLICT = 2'd1,
    ACT_INC      = 2'd2
  } act_e;

  typedef struct packed {
    act_e   act;
    fault_e fault;
    logic   opnd;   // 0 target, 1 parent
  } verdict_t;

  localparam logic [2:0] PT_CTRL = 3'd0;
  localparam logic [2:0] PT_REG  = 3'd1;
  localparam logic [2:0] PT_THR  = 3'd2;
  localparam logic [2:0] PT_TRIM = 3'd3;

  localparam int FB_CF = 0;
  localparam int FB_PF = 1;
  localparam int FB_AF = 2;
  localparam int FB_ZF = 3;
  localparam int FB_SF = 4;
  localparam int FB_OF = 5;
  localparam int FLAG_W = 6;

endpackage

// File: rtl/ccu_check.sv
module ccu_check
  import ccu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        priv_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic              tgt_prot_i,
  input  logic              tgt_valid_i,
  input  logic [2:0]        tgt_type_i,
  input  logic [ADDR_W-1:0] tgt_back_i,
  input  logic              tgt_busy_i,
  input  logic [ADDR_W-1:0] par_addr_i,
  input  logic              par_prot_i,
  output verdict_t          verdict_o,
  output logic              chk_priv_bad_o,
  output logic              chk_type_bad_o
);

  localparam int PAGE_BITS = 12;

  function automatic logic page_aligned(input logic [ADDR_W-1:0] a);
    return a[PAGE_BITS-1:0] == '0;
  endfunction

  function automatic logic type_known(input logic [2:0] t);
    return (t == PT_CTRL) || (t == PT_REG) || (t == PT_THR) || (t == PT_TRIM);
  endfunction

  function automatic logic [ADDR_W-1:0] owner_of(input logic [2:0] t,
                                                 input logic [ADDR_W-1:0] own,
                                                 input logic [ADDR_W-1:0] back);
    return (t == PT_CTRL) ? own : back;
  endfunction

  logic              misaligned;
  logic [ADDR_W-1:0] owner_addr;

  assign chk_priv_bad_o = (priv_i != 2'd0);
  assign misaligned     = !page_aligned(tgt_addr_i);
  assign chk_type_bad_o = !type_known(tgt_type_i);
  assign owner_addr     = owner_of(tgt_type_i, tgt_addr_i, tgt_back_i);

  always_comb begin
    verdict_o = '{act: ACT_INC, fault: FLT_NONE, opnd: 1'b0};
    if (chk_priv_bad_o)
      verdict_o = '{act: ACT_FAULT, fault: FLT_GP, opnd: 1'b0};
    else if (misaligned)
      verdict_o = '{act: ACT_FAULT, fault: FLT_GP, opnd: 1'b0};
    else if (!tgt_prot_i)
      verdict_o = '{act: ACT_FAULT, fault: FLT_PF, opnd: 1'b0};
    else if (!par_prot_i)
      verdict_o = '{act: ACT_FAULT, fault: FLT_PF, opnd: 1'b1};
    else if (tgt_busy_i)
      verdict_o = '{act: ACT_CONFLICT, fault: FLT_NONE, opnd: 1'b0};
    else if (!tgt_valid_i)
      verdict_o = '{act: ACT_FAULT, fault: FLT_PF, opnd: 1'b0};
    else if (chk_type_bad_o)
      verdict_o = '{act: ACT_FAULT, fault: FLT_PF, opnd: 1'b0};
    else if (owner_addr != par_addr_i)
      verdict_o = '{act: ACT_FAULT, fault: FLT_GP, opnd: 1'b1};
  end

endmodule

// File: rtl/ccu_bank.sv
module ccu_bank #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 64,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] old_o,
  output logic [CNT_W-1:0] next_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] mem [SLOTS];

  function automatic logic would_wrap(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  assign old_o  = mem[idx_i];
  assign ovf_o  = would_wrap(old_o);
  assign next_o = old_o + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else if (inc_en_i && !ovf_o) begin
      mem[idx_i] <= next_o;
    end
  end

  // R7: a non-wrapping increment lands exactly one above the old value
  p_incr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en_i && !ovf_o) |=> (mem[$past(idx_i)] == $past(old_o) + CNT_W'(1)));

  // R8: a wrapping increment is undone, leaving the slot as it was
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en_i && ovf_o) |=> (mem[$past(idx_i)] == $past(old_o)));

endmodule

// File: rtl/child_count_unit.sv
module child_count_unit
  import ccu_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          CNT_W       = 64,
  parameter int          SLOTS       = 4,
  parameter int          RC_W        = 64,
  parameter logic [63:0] CONFLICT_RC = 64'd7,
  parameter logic [63:0] BADCNT_RC   = 64'd29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        priv_i,
  input  logic [5:0]        flags_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic              tgt_prot_i,
  input  logic              tgt_valid_i,
  input  logic [2:0]        tgt_type_i,
  input  logic [ADDR_W-1:0] tgt_back_i,
  input  logic              tgt_busy_i,
  input  logic [ADDR_W-1:0] par_addr_i,
  input  logic              par_prot_i,
  output logic              done_o,
  output logic [1:0]        fault_o,
  output logic              fault_opnd_o,
  output logic [RC_W-1:0]   rc_o,
  output logic [5:0]        flags_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam int IDX_W = $clog2(SLOTS);
  localparam int IDX_LO = 12;
  localparam logic [5:0] ZF_ONLY = 6'(1 << FB_ZF);

  verdict_t          verdict_d, verdict_q;
  logic              priv_bad, type_bad;
  logic              accept, pend_q;
  logic [5:0]        flags_cap_q;
  logic [IDX_W-1:0]  idx_q;
  logic              inc_en, cnt_ovf;
  logic [CNT_W-1:0]  cnt_old, cnt_next;

  ccu_check #(.ADDR_W(ADDR_W)) u_check (
    .priv_i        (priv_i),
    .tgt_addr_i    (tgt_addr_i),
    .tgt_prot_i    (tgt_prot_i),
    .tgt_valid_i   (tgt_valid_i),
    .tgt_type_i    (tgt_type_i),
    .tgt_back_i    (tgt_back_i),
    .tgt_busy_i    (tgt_busy_i),
    .par_addr_i    (par_addr_i),
    .par_prot_i    (par_prot_i),
    .verdict_o     (verdict_d),
    .chk_priv_bad_o(priv_bad),
    .chk_type_bad_o(type_bad)
  );

  assign accept = start_i && !pend_q;
  assign inc_en = pend_q && (verdict_q.act == ACT_INC);

  ccu_bank #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en_i(inc_en),
    .idx_i   (idx_q),
    .old_o   (cnt_old),
    .next_o  (cnt_next),
    .ovf_o   (cnt_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      verdict_q   <= '{act: ACT_FAULT, fault: FLT_NONE, opnd: 1'b0};
      flags_cap_q <= '0;
      idx_q       <= '0;
    end else begin
      if (accept) begin
        pend_q      <= 1'b1;
        verdict_q   <= verdict_d;
        flags_cap_q <= flags_i;
        idx_q       <= par_addr_i[IDX_LO +: IDX_W];
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o       <= 1'b0;
      fault_o      <= FLT_NONE;
      fault_opnd_o <= 1'b0;
      rc_o         <= '0;
      flags_o      <= '0;
      count_o      <= '0;
    end else begin
      done_o <= pend_q;
      if (pend_q) begin
        fault_o      <= FLT_NONE;
        fault_opnd_o <= 1'b0;
        unique case (verdict_q.act)
          ACT_FAULT: begin
            fault_o      <= verdict_q.fault;
            fault_opnd_o <= verdict_q.opnd;
            rc_o         <= '0;
            flags_o      <= flags_cap_q;
            count_o      <= '0;
          end
          ACT_CONFLICT: begin
            rc_o    <= RC_W'(CONFLICT_RC);
            flags_o <= ZF_ONLY;
            count_o <= cnt_old;
          end
          default: begin
            if (cnt_ovf) begin
              rc_o    <= RC_W'(BADCNT_RC);
              flags_o <= ZF_ONLY;
              count_o <= cnt_old;
            end else begin
              rc_o    <= '0;
              flags_o <= '0;
              count_o <= cnt_next;
            end
          end
        endcase
      end
    end
  end

  // R1: a bad privilege level ends in a general-protection fault two edges later
  p_priv_gp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && priv_bad) |=> ##1 (done_o && fault_o == FLT_GP && !fault_opnd_o));

  // R5: an unknown type with otherwise clean operands ends in a page fault on the target
  p_type_pf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && type_bad && !priv_bad && tgt_addr_i[11:0] == '0 && tgt_prot_i
     && par_prot_i && !tgt_busy_i && tgt_valid_i)
    |=> ##1 (fault_o == FLT_PF && !fault_opnd_o));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: a fault returns the caller's flags untouched and a zero code
  p_fault_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o != FLT_NONE) |-> (rc_o == '0 && flags_o == flags_cap_q));

  // R4: a conflict return carries ZF alone
  p_conflict_zf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o == FLT_NONE && rc_o == RC_W'(CONFLICT_RC)) |-> (flags_o == ZF_ONLY));

endmodule

// File: tb/child_count_unit_tb.sv
module child_count_unit_tb;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 4;
  localparam int SLOTS  = 4;
  localparam int RC_W   = 64;
  localparam logic [63:0] CRC = 64'd7;
  localparam logic [63:0] BRC = 64'd29;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [1:0]        priv_i = '0;
  logic [5:0]        flags_i = '0;
  logic [ADDR_W-1:0] tgt_addr_i = '0;
  logic              tgt_prot_i = 1'b0;
  logic              tgt_valid_i = 1'b0;
  logic [2:0]        tgt_type_i = '0;
  logic [ADDR_W-1:0] tgt_back_i = '0;
  logic              tgt_busy_i = 1'b0;
  logic [ADDR_W-1:0] par_addr_i = '0;
  logic              par_prot_i = 1'b0;
  logic              done_o;
  logic [1:0]        fault_o;
  logic              fault_opnd_o;
  logic [RC_W-1:0]   rc_o;
  logic [5:0]        flags_o;
  logic [CNT_W-1:0]  count_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int exp_cnt [SLOTS];

  always #5 clk = ~clk;

  child_count_unit #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLOTS(SLOTS), .RC_W(RC_W),
    .CONFLICT_RC(CRC), .BADCNT_RC(BRC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .priv_i(priv_i), .flags_i(flags_i),
    .tgt_addr_i(tgt_addr_i), .tgt_prot_i(tgt_prot_i), .tgt_valid_i(tgt_valid_i),
    .tgt_type_i(tgt_type_i), .tgt_back_i(tgt_back_i), .tgt_busy_i(tgt_busy_i),
    .par_addr_i(par_addr_i), .par_prot_i(par_prot_i), .done_o(done_o), .fault_o(fault_o),
    .fault_opnd_o(fault_opnd_o), .rc_o(rc_o), .flags_o(flags_o), .count_o(count_o)
  );

  function automatic logic [ADDR_W-1:0] page(input int s);
    return ADDR_W'(32'h0010_0000 + (s << 12));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clean(input int s);
    priv_i = 2'd0; flags_i = 6'h00;
    tgt_addr_i = page(s); tgt_prot_i = 1'b1; tgt_valid_i = 1'b1;
    tgt_type_i = 3'd1; tgt_back_i = page(s); tgt_busy_i = 1'b0;
    par_addr_i = page(s); par_prot_i = 1'b1;
  endtask

  task automatic fire();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_fault(input string req, input logic [1:0] f, input logic op);
    chk(done_o == 1'b1, req, done_o, 1);
    chk(fault_o == f, req, fault_o, f);
    chk(fault_opnd_o == op, req, fault_opnd_o, op);
    chk(rc_o == 0, req, rc_o, 0);
    chk(flags_o == flags_i, req, flags_o, flags_i);
    chk(count_o == 0, req, count_o, 0);
  endtask

  task automatic expect_inc(input string req, input int s);
    if (exp_cnt[s] == (1 << CNT_W) - 1) begin
      chk(rc_o == BRC, req, rc_o, BRC);
      chk(flags_o == 6'h08, req, flags_o, 6'h08);
    end else begin
      exp_cnt[s]++;
      chk(rc_o == 0, req, rc_o, 0);
      chk(flags_o == 6'h00, req, flags_o, 0);
    end
    chk(done_o == 1'b1 && fault_o == 2'd0, req, fault_o, 0);
    chk(count_o == CNT_W'(exp_cnt[s]), req, count_o, exp_cnt[s]);
  endtask

  task automatic t_reset();
    chk(done_o == 0 && fault_o == 0 && rc_o == 0 && count_o == 0, "R11 reset", done_o, 0);
  endtask

  task automatic t_priv();
    clean(0); priv_i = 2'd3; tgt_addr_i = page(0) + 4; tgt_prot_i = 1'b0; flags_i = 6'h2A;
    fire(); expect_fault("R1 privilege", 2'd1, 1'b0);
  endtask

  task automatic t_align();
    clean(0); tgt_addr_i = page(0) + 32'h10; tgt_prot_i = 1'b0; flags_i = 6'h15;
    fire(); expect_fault("R2 alignment", 2'd1, 1'b0);
  endtask

  task automatic t_pf_order();
    clean(0); tgt_prot_i = 1'b0; par_prot_i = 1'b0; tgt_busy_i = 1'b1; flags_i = 6'h3F;
    fire(); expect_fault("R3 target unprotected", 2'd2, 1'b0);
    clean(0); par_prot_i = 1'b0; tgt_busy_i = 1'b1; tgt_valid_i = 1'b0; flags_i = 6'h01;
    fire(); expect_fault("R3 parent unprotected", 2'd2, 1'b1);
    clean(0); tgt_valid_i = 1'b0; tgt_type_i = 3'd6; flags_i = 6'h22;
    fire(); expect_fault("R3 invalid target", 2'd2, 1'b0);
  endtask

  task automatic t_conflict();
    clean(0); tgt_busy_i = 1'b1; tgt_valid_i = 1'b0; flags_i = 6'h37;
    fire();
    chk(fault_o == 0 && done_o, "R4 conflict no fault", fault_o, 0);
    chk(rc_o == CRC, "R4 conflict code", rc_o, CRC);
    chk(flags_o == 6'h08, "R4 conflict flags", flags_o, 6'h08);
    chk(count_o == CNT_W'(exp_cnt[0]), "R4 counter unchanged", count_o, exp_cnt[0]);
  endtask

  task automatic t_types();
    clean(0); tgt_type_i = 3'd5;
    fire(); expect_fault("R5 unknown type", 2'd2, 1'b0);
    clean(0); tgt_type_i = 3'd2; tgt_addr_i = page(3); flags_i = 6'h3F;
    fire(); expect_inc("R5 thread-control via back-pointer", 0);
    clean(0); tgt_type_i = 3'd3; tgt_addr_i = page(2);
    fire(); expect_inc("R5 trimmed via back-pointer", 0);
    clean(0); tgt_type_i = 3'd0; tgt_back_i = page(1);
    fire(); expect_inc("R5 control page uses own address", 0);
    clean(0); tgt_type_i = 3'd0; tgt_addr_i = page(1);
    fire(); expect_fault("R5 control page address differs", 2'd1, 1'b1);
  endtask

  task automatic t_mismatch();
    clean(1); tgt_back_i = page(2); flags_i = 6'h0C;
    fire(); expect_fault("R6 parent mismatch", 2'd1, 1'b1);
    clean(1); flags_i = 6'h3F;
    fire(); expect_inc("R7 success after fault (R9 no change)", 1);
  endtask

  task automatic t_slots();
    clean(0); fire(); expect_inc("R11 slot 0 independent", 0);
    clean(3); fire(); expect_inc("R11 slot 3 starts at one", 3);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < (1 << CNT_W) - 1; i++) begin
      clean(2); fire(); expect_inc("R7 fill slot 2", 2);
    end
    clean(2); flags_i = 6'h37; fire(); expect_inc("R8 wrap undone", 2);
    clean(2); fire(); expect_inc("R8 wrap undone again", 2);
  endtask

  task automatic t_pending();
    int pulses = 0;
    clean(1);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) begin start_i = 1'b0; if (done_o) pulses++; end
    for (int i = 0; i < 4; i++) @(negedge clk) if (done_o) pulses++;
    chk(pulses == 1, "R10 second start ignored", pulses, 1);
    exp_cnt[1]++;
    clean(1); fire(); expect_inc("R10 single increment taken", 1);
    @(negedge clk);
    chk(done_o == 0, "R10 done is one cycle", done_o, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_priv();
    t_align();
    t_pf_order();
    t_conflict();
    t_types();
    t_conflict();
    t_mismatch();
    t_slots();
    t_overflow();
    t_pending();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule